// File: doc/BRIEF.md
# Operand Address and Immediate Former

This block turns an operand field, already split out of an instruction by the decoder, into either a 24-bit memory or branch target address or a 32-bit immediate value. A request carries a mode, a size code, the raw field and the address of the byte that follows the current instruction. One cycle later the result appears on registered outputs, together with a one-cycle completion strobe.

Three address forms are handled. Short absolute operands select the top page of the space. Medium absolute operands are widened by sign extension. Full-width absolute operands pass straight through. PC-relative operands add a sign-extended displacement to the next-instruction address, wrap within 24 bits, and report a target that is not on a word boundary. Immediate operands are widened with zeros, including the short forms that carry a bit number or a trap vector index.

Only the low 16 address bits reach memory. Because of this, the unit also exposes that folded window address. It flags a full-width absolute operand whose upper byte differs from the sign-extended form, because such an operand only reaches memory through aliasing.

Top module: `eff_addr_unit`

## Requirements
- R1: Mode 2'b00 (absolute) with size 2'b00 gives ea = {16'hFFFF, field[7:0]}.
- R2: Mode 2'b00 with size 2'b01 gives ea = field[15:0] with bits 23:16 all equal to field[15].
- R3: Mode 2'b00 with size 2'b10 or 2'b11 gives ea = field[23:0] unchanged.
- R4: win_addr always equals ea[15:0]. alias_err is 1 only for mode 2'b00 with size 2'b10/2'b11 when field[23:16] differs from eight copies of field[15]; otherwise it is 0.
- R5: Mode 2'b01 (PC-relative) gives ea = next_pc + sign-extended displacement, modulo 2^24, with no carry reported. The displacement is field[7:0] for size 2'b00 and field[15:0] for any other size.
- R6: odd_err equals bit 0 of the PC-relative target in mode 2'b01, and is 0 in every other mode.
- R7: Mode 2'b10 (immediate) gives imm = field[7:0] zero-extended for size 2'b00, field[15:0] zero-extended for size 2'b01, and field[31:0] for sizes 2'b10/2'b11.
- R8: Mode 2'b11 (short immediate) gives imm = field[2:0] zero-extended (bit number) for size 2'b00, and field[1:0] zero-extended (trap vector index 0 to 3) for any other size.
- R9: imm is 0 in modes 2'b00 and 2'b01; ea is 0 in modes 2'b10 and 2'b11.
- R10: done is 1 in exactly the cycle after each cycle with req_valid high. Results appear in that same cycle, and a request is accepted every cycle.
- R11: After reset all outputs are 0. In a cycle that follows no request, every output other than done keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 2 | 00 absolute, 01 PC-relative, 10 immediate, 11 short immediate |
| req_size | input | 2 | Operand size code, meaning depends on mode |
| req_field | input | 32 | Raw operand field from the decoder |
| req_next_pc | input | 24 | Address of the first byte of the following instruction |
| done | output | 1 | Result valid strobe |
| ea | output | 24 | Effective address |
| win_addr | output | 16 | Address as seen by the 16-bit memory window |
| imm | output | 32 | Immediate value |
| odd_err | output | 1 | PC-relative target is odd |
| alias_err | output | 1 | Full absolute address reaches memory only by folding |

## Verification
The register stage can present one result while it captures the next request in the same cycle. Back-to-back requests therefore overlap completion with acceptance. The bench drives runs of consecutive requests with mixed modes, interleaved with idle gaps. A scoreboard pops one expected item for each done cycle, so a dropped, repeated or reordered result shows up as a mismatch or as a leftover in the queue. In the idle cycles, the monitor confirms that the outputs hold the last result.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int EA_W    = 24;
    localparam int IMM_W   = 32;
    localparam int SHORT_W = 8;
    localparam int MID_W   = 16;
    localparam int BIT_W   = 3;
    localparam int VEC_W   = 2;

    typedef enum logic [1:0] {
        MODE_ABS   = 2'b00,
        MODE_PCREL = 2'b01,
        MODE_IMM   = 2'b10,
        MODE_SHORT = 2'b11
    } ea_mode_e;

    localparam logic [1:0] SZ_NARROW = 2'b00;
    localparam logic [1:0] SZ_MID    = 2'b01;

endpackage

// File: rtl/ea_abs_path.sv
module ea_abs_path #(
    parameter int AW      = ea_pkg::EA_W,
    parameter int SHORT_W = ea_pkg::SHORT_W,
    parameter int MID_W   = ea_pkg::MID_W
) (
    input  logic [AW-1:0] field,
    input  logic [1:0]    size,
    output logic [AW-1:0] addr,
    output logic          alias_flag
);
    localparam int PAD_S = AW - SHORT_W;
    localparam int PAD_M = AW - MID_W;

    logic [PAD_M-1:0] ext_bits;

    always_comb begin
        ext_bits   = {PAD_M{field[MID_W-1]}};
        alias_flag = 1'b0;
        unique case (size)
            ea_pkg::SZ_NARROW: addr = {{PAD_S{1'b1}}, field[SHORT_W-1:0]};
            ea_pkg::SZ_MID:    addr = {ext_bits, field[MID_W-1:0]};
            default: begin
                addr       = field;
                alias_flag = (field[AW-1:MID_W] != ext_bits);
            end
        endcase
    end
endmodule

// File: rtl/ea_pcrel_path.sv
module ea_pcrel_path #(
    parameter int AW      = ea_pkg::EA_W,
    parameter int SHORT_W = ea_pkg::SHORT_W,
    parameter int MID_W   = ea_pkg::MID_W
) (
    input  logic [AW-1:0]    next_pc,
    input  logic [MID_W-1:0] disp,
    input  logic [1:0]       size,
    output logic [AW-1:0]    target,
    output logic             odd
);
    localparam int PAD_S = AW - SHORT_W;
    localparam int PAD_M = AW - MID_W;

    logic [AW-1:0] offset;

    always_comb begin
        if (size == ea_pkg::SZ_NARROW)
            offset = {{PAD_S{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
        else
            offset = {{PAD_M{disp[MID_W-1]}}, disp};
        target = next_pc + offset;
        odd    = target[0];
    end
endmodule

// File: rtl/ea_imm_path.sv
module ea_imm_path #(
    parameter int DW      = ea_pkg::IMM_W,
    parameter int SHORT_W = ea_pkg::SHORT_W,
    parameter int MID_W   = ea_pkg::MID_W,
    parameter int BIT_W   = ea_pkg::BIT_W,
    parameter int VEC_W   = ea_pkg::VEC_W
) (
    input  logic [DW-1:0] field,
    input  logic [1:0]    size,
    input  logic          short_form,
    output logic [DW-1:0] value
);
    always_comb begin
        if (short_form) begin
            if (size == ea_pkg::SZ_NARROW)
                value = {{(DW-BIT_W){1'b0}}, field[BIT_W-1:0]};
            else
                value = {{(DW-VEC_W){1'b0}}, field[VEC_W-1:0]};
        end else begin
            unique case (size)
                ea_pkg::SZ_NARROW: value = {{(DW-SHORT_W){1'b0}}, field[SHORT_W-1:0]};
                ea_pkg::SZ_MID:    value = {{(DW-MID_W){1'b0}}, field[MID_W-1:0]};
                default:           value = field;
            endcase
        end
    end
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit #(
    parameter int AW    = ea_pkg::EA_W,
    parameter int DW    = ea_pkg::IMM_W,
    parameter int WIN_W = ea_pkg::MID_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_mode,
    input  logic [1:0]    req_size,
    input  logic [DW-1:0] req_field,
    input  logic [AW-1:0] req_next_pc,
    output logic          done,
    output logic [AW-1:0] ea,
    output logic [WIN_W-1:0] win_addr,
    output logic [DW-1:0] imm,
    output logic          odd_err,
    output logic          alias_err
);
    import ea_pkg::*;

    typedef struct packed {
        logic          done;
        logic [AW-1:0] ea;
        logic [DW-1:0] imm;
        logic          odd;
        logic          alias_f;
    } res_t;

    res_t res_d, res_q;

    logic [AW-1:0] abs_addr;
    logic          abs_alias;
    logic [AW-1:0] rel_target;
    logic          rel_odd;
    logic [DW-1:0] imm_value;
    ea_mode_e      mode;

    assign mode = ea_mode_e'(req_mode);

    ea_abs_path #(.AW(AW), .SHORT_W(SHORT_W), .MID_W(MID_W)) u_abs (
        .field      (req_field[AW-1:0]),
        .size       (req_size),
        .addr       (abs_addr),
        .alias_flag (abs_alias)
    );

    ea_pcrel_path #(.AW(AW), .SHORT_W(SHORT_W), .MID_W(MID_W)) u_rel (
        .next_pc (req_next_pc),
        .disp    (req_field[MID_W-1:0]),
        .size    (req_size),
        .target  (rel_target),
        .odd     (rel_odd)
    );

    ea_imm_path #(.DW(DW), .SHORT_W(SHORT_W), .MID_W(MID_W),
                  .BIT_W(BIT_W), .VEC_W(VEC_W)) u_imm (
        .field      (req_field),
        .size       (req_size),
        .short_form (mode == MODE_SHORT),
        .value      (imm_value)
    );

    always_comb begin
        res_d      = res_q;
        res_d.done = req_valid;
        if (req_valid) begin
            res_d.ea      = '0;
            res_d.imm     = '0;
            res_d.odd     = 1'b0;
            res_d.alias_f = 1'b0;
            unique case (mode)
                MODE_ABS: begin
                    res_d.ea      = abs_addr;
                    res_d.alias_f = abs_alias;
                end
                MODE_PCREL: begin
                    res_d.ea  = rel_target;
                    res_d.odd = rel_odd;
                end
                default: res_d.imm = imm_value;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign done      = res_q.done;
    assign ea        = res_q.ea;
    assign win_addr  = res_q.ea[WIN_W-1:0];
    assign imm       = res_q.imm;
    assign odd_err   = res_q.odd;
    assign alias_err = res_q.alias_f;

    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done); // R10
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !done); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(ea) && $stable(imm) && $stable(odd_err) && $stable(alias_err))); // R11
    AST_SHORT_ABS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'b00 && req_size == 2'b00) |=> (ea[AW-1:SHORT_W] == '1)); // R1
    AST_ODD_ONLY_REL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode != 2'b01) |=> !odd_err); // R6
    AST_ALIAS_ONLY_ABS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode != 2'b00) |=> !alias_err); // R4
    AST_IMM_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode[1]) |=> (ea == '0)); // R9
    AST_ADDR_NO_IMM: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_mode[1]) |=> (imm == '0)); // R9

endmodule

// File: tb/test_eff_addr_unit.sv
module test_eff_addr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_mode = 2'b00;
    logic [1:0]  req_size = 2'b00;
    logic [31:0] req_field = '0;
    logic [23:0] req_next_pc = '0;
    logic        done;
    logic [23:0] ea;
    logic [15:0] win_addr;
    logic [31:0] imm;
    logic        odd_err;
    logic        alias_err;

    always #10 clk = ~clk;

    eff_addr_unit i_eff_addr_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_size(req_size), .req_field(req_field), .req_next_pc(req_next_pc),
        .done(done), .ea(ea), .win_addr(win_addr), .imm(imm),
        .odd_err(odd_err), .alias_err(alias_err)
    );

    typedef struct {
        logic [23:0] ea;
        logic [31:0] imm;
        logic        odd;
        logic        al;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t last;
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   monitor_on = 0;
    bit   finished = 0;

    function automatic exp_t model(logic [1:0] m, logic [1:0] s, logic [31:0] f, logic [23:0] pc);
        exp_t e;
        e.ea = '0; e.imm = '0; e.odd = 0; e.al = 0;
        case (m)
            2'b00: begin
                if (s == 2'b00)      begin e.ea = {16'hFFFF, f[7:0]};       e.tag = "R1"; end
                else if (s == 2'b01) begin e.ea = {{8{f[15]}}, f[15:0]};    e.tag = "R2"; end
                else begin
                    e.ea  = f[23:0];
                    e.al  = (f[23:16] != {8{f[15]}});
                    e.tag = "R3/R4";
                end
            end
            2'b01: begin
                if (s == 2'b00) e.ea = pc + {{16{f[7]}}, f[7:0]};
                else            e.ea = pc + {{8{f[15]}}, f[15:0]};
                e.odd = e.ea[0];
                e.tag = "R5/R6";
            end
            2'b10: begin
                if (s == 2'b00)      e.imm = {24'h0, f[7:0]};
                else if (s == 2'b01) e.imm = {16'h0, f[15:0]};
                else                 e.imm = f;
                e.tag = "R7/R9";
            end
            default: begin
                if (s == 2'b00) e.imm = {29'h0, f[2:0]};
                else            e.imm = {30'h0, f[1:0]};
                e.tag = "R8/R9";
            end
        endcase
        return e;
    endfunction

    task automatic check_outs(exp_t e, string tag);
        n_checks++;
        if (ea !== e.ea || imm !== e.imm || odd_err !== e.odd || alias_err !== e.al
            || win_addr !== e.ea[15:0]) begin
            n_fail++;
            $display("FAIL %s: ea=%h win=%h imm=%h odd=%b alias=%b expected ea=%h win=%h imm=%h odd=%b alias=%b",
                     tag, ea, win_addr, imm, odd_err, alias_err,
                     e.ea, e.ea[15:0], e.imm, e.odd, e.al);
        end
    endtask

    task automatic send(logic [1:0] m, logic [1:0] s, logic [31:0] f, logic [23:0] pc);
        @(negedge clk);
        req_valid   = 1'b1;
        req_mode    = m;
        req_size    = s;
        req_field   = f;
        req_next_pc = pc;
        q.push_back(model(m, s, f, pc));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_field = 32'hA5A5_5A5A;
            req_mode  = 2'b01;
            req_next_pc = 24'h123457;
        end
    endtask

    // Monitor: pop one expectation for each done, check holding otherwise (R10, R11)
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (monitor_on) begin
                if (done) begin
                    if (q.size() == 0) begin
                        n_checks++; n_fail++;
                        $display("FAIL R10: done=1 with no request pending, expected done=0");
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        check_outs(e, e.tag);
                        last = e;
                    end
                end else begin
                    if (q.size() != 0) begin
                        n_checks++; n_fail++;
                        $display("FAIL R10: done=0 with %0d results pending, expected done=1", q.size());
                    end
                    check_outs(last, "R11 hold");
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        last.ea = '0; last.imm = '0; last.odd = 0; last.al = 0; last.tag = "R11";
        repeat (3) @(negedge clk);
        // R11 reset state
        n_checks++;
        if (done !== 1'b0 || ea !== '0 || imm !== '0 || odd_err !== 1'b0 || alias_err !== 1'b0 || win_addr !== '0) begin
            n_fail++;
            $display("FAIL R11 reset: done=%b ea=%h imm=%h odd=%b alias=%b expected all zero",
                     done, ea, imm, odd_err, alias_err);
        end
        rst_n = 1'b1;
        @(negedge clk);
        monitor_on = 1;
        idle(2);

        // R1 short absolute
        send(2'b00, 2'b00, 32'hFFFF_FF34, 24'h000000);
        send(2'b00, 2'b00, 32'h0000_0000, 24'h000000);
        idle(1);
        // R2 medium absolute, both signs
        send(2'b00, 2'b01, 32'h0012_7FFE, 24'h0);
        send(2'b00, 2'b01, 32'h0000_8000, 24'h0);
        send(2'b00, 2'b01, 32'hFFFF_FFFF, 24'h0);
        // R3/R4 full absolute, aliasing and not
        send(2'b00, 2'b10, 32'h0012_3456, 24'h0);
        send(2'b00, 2'b10, 32'h00FF_8001, 24'h0);
        send(2'b00, 2'b11, 32'h0000_ABCD, 24'h0);
        send(2'b00, 2'b11, 32'hAA00_1234, 24'h0);
        idle(2);
        // R5/R6 PC-relative, short and long displacement
        send(2'b01, 2'b00, 32'h0000_0080, 24'h001000);
        send(2'b01, 2'b00, 32'h0000_007F, 24'h001000);
        send(2'b01, 2'b00, 32'hFFFF_FF80, 24'h000010);
        send(2'b01, 2'b01, 32'h0000_0020, 24'hFFFFF0);
        send(2'b01, 2'b01, 32'h0000_8000, 24'h010000);
        send(2'b01, 2'b10, 32'h0000_7FFF, 24'h000002);
        send(2'b01, 2'b11, 32'h0000_FFFE, 24'h000002);
        idle(1);
        // R7 immediates
        send(2'b10, 2'b00, 32'hDEAD_BEEF, 24'hFFFFFF);
        send(2'b10, 2'b01, 32'hDEAD_BEEF, 24'h0);
        send(2'b10, 2'b10, 32'hDEAD_BEEF, 24'h0);
        send(2'b10, 2'b11, 32'h8000_0001, 24'h0);
        idle(3);
        // R8 short immediates
        send(2'b11, 2'b00, 32'hFFFF_FFFF, 24'h0);
        send(2'b11, 2'b00, 32'h0000_0005, 24'h0);
        send(2'b11, 2'b01, 32'hFFFF_FFFF, 24'h0);
        send(2'b11, 2'b10, 32'h0000_0002, 24'h0);
        send(2'b11, 2'b11, 32'h0000_0001, 24'h0);
        // R10 mixed back-to-back after immediates
        send(2'b00, 2'b00, 32'h0000_0001, 24'h0);
        send(2'b01, 2'b00, 32'h0000_0003, 24'h000100);
        send(2'b10, 2'b01, 32'h0000_1234, 24'h0);
        send(2'b00, 2'b10, 32'h0080_0000, 24'h0);
        idle(4);

        if (q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R10: %0d results never produced, expected 0", q.size());
        end
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule